// File: doc/BRIEF.md
# SPI Register Write Port

This block is a slave serial port through which a host fills an internal bank of 8-bit registers. The host frames each transfer with an active-low chip select and shifts bits in on a serial data line, sampled on the rising edge of the serial clock. Chip select, clock and data are brought into the system clock domain by synchronizer chains, so the serial clock must run well below the system clock. For the defaults this means at least four system cycles per serial half period.

Every transfer opens with an identification byte. If it matches the block's fixed value, the next byte is taken as a register pointer and each byte after that is written into the bank. A flag in the pointer byte chooses one of two modes. In the stepping mode, successive data bytes land in consecutive registers. In the other mode, every data byte overwrites the same register. The write strobe, address and data that feed the bank are also driven out on ports. A plain parallel lookup port lets the surrounding logic read any register.

The serial input cannot be stalled, so the block applies no back-pressure. Each completed data byte produces exactly one write, with no handshake.

Top module: `spi_regport`

## Requirements
- R1: After reset every register in the bank reads 0x00 and `wr_en` is low.
- R2: The first complete byte of a transfer must equal 0x9E (1001_1110). Any other value leaves the bank unchanged and produces no write strobe for the rest of that transfer.
- R3: The second byte is the pointer. Bits 6:0 select the register written by the first data byte.
- R4: Bytes are shifted most significant bit first. A data byte sent as the bit stream 0,0,0,0,0,0,0,1 is stored as 0x01.
- R5: When pointer bit 7 is 1, each following data byte goes to the register one above the previous one.
- R6: When pointer bit 7 is 0, every data byte of the transfer writes the pointed register, and the last byte remains.
- R7: In stepping mode the register index wraps from 127 to 0.
- R8: Raising chip select in the middle of a byte discards the partial byte and clears the bit count, so the next transfer decodes from its first bit.
- R9: A transfer that ends after the identification byte or after the pointer byte writes nothing.
- R10: `wr_en` is a single-cycle pulse, issued once per complete data byte and never while chip select is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous-assert reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock; data sampled on its rising edge |
| sdi | input | 1 | Serial data in, MSB first |
| rd_addr | input | 7 | Parallel lookup address into the bank |
| rd_data | output | 8 | Register contents at `rd_addr` (combinational) |
| wr_en | output | 1 | Write strobe into the bank, one cycle per data byte |
| wr_addr | output | 7 | Register index for the current write |
| wr_data | output | 8 | Byte value for the current write |

## Verification
The rising edge of the serial clock that completes a byte passes through the following stages in system clocks:

- Two synchronizer stages, with the edge detected in the second.
- The byte-complete register one clock later.
- `wr_en` one clock after that.
- The bank updated on the fifth clock after the pin changed.

The bench keeps every transfer at least eight system cycles past its last rising edge before raising chip select. It then idles twelve more cycles before reading the bank. Each lookup holds the read address for a full clock and samples on the falling edge. Write pulses are counted on falling edges, so each count is compared only after the transfer has settled.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

  // Frame decoder progress within one chip-select window
  typedef enum logic [1:0] {
    FR_ID   = 2'd0,
    FR_PTR  = 2'd1,
    FR_DATA = 2'd2,
    FR_SKIP = 2'd3
  } frame_st_e;

endpackage

// File: rtl/spi_regport_sync.sv
module spi_regport_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic sdi,
  output logic cs_idle,
  output logic sclk_rise,
  output logic sdi_s
);

  logic [STAGES-1:0] cs_q;
  logic [STAGES-1:0] ck_q;
  logic [STAGES-1:0] d_q;
  logic              ck_prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cs_q <= '1;
          ck_q <= '0;
          d_q  <= '0;
        end else begin
          cs_q <= cs_n;
          ck_q <= sclk;
          d_q  <= sdi;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cs_q <= '1;
          ck_q <= '0;
          d_q  <= '0;
        end else begin
          cs_q <= {cs_q[STAGES-2:0], cs_n};
          ck_q <= {ck_q[STAGES-2:0], sclk};
          d_q  <= {d_q[STAGES-2:0], sdi};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ck_prev <= 1'b0;
    else        ck_prev <= ck_q[STAGES-1];
  end

  assign cs_idle   = cs_q[STAGES-1];
  assign sclk_rise = ck_q[STAGES-1] & ~ck_prev;
  assign sdi_s     = d_q[STAGES-1];

endmodule

// File: rtl/spi_regport_rx.sv
module spi_regport_rx #(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_idle,
  input  logic              sclk_rise,
  input  logic              sdi_s,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              byte_valid,
  output logic [DATA_W-1:0] rx_byte
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] shreg;
  logic [DATA_W-1:0] next_sh;

  assign next_sh = {shreg[DATA_W-2:0], sdi_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt    <= '0;
      shreg      <= '0;
      byte_valid <= 1'b0;
      rx_byte    <= '0;
    end else begin
      byte_valid <= 1'b0;
      if (cs_idle) begin
        bit_cnt <= '0;
      end else if (sclk_rise) begin
        shreg <= next_sh;
        if (bit_cnt == LAST) begin
          bit_cnt    <= '0;
          byte_valid <= 1'b1;
          rx_byte    <= next_sh;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/spi_regport_frame.sv
module spi_regport_frame
  import spi_regport_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7,
  parameter logic [DATA_W-1:0] CHIP_ID = 8'b1001_1110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_idle,
  input  logic              byte_valid,
  input  logic [DATA_W-1:0] rx_byte,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);

  frame_st_e         state;
  logic [ADDR_W-1:0] ptr;
  logic              step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= FR_ID;
      ptr     <= '0;
      step    <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (cs_idle) begin
        state <= FR_ID;
      end else if (byte_valid) begin
        case (state)
          FR_ID:   state <= (rx_byte == CHIP_ID) ? FR_PTR : FR_SKIP;
          FR_PTR: begin
            ptr   <= rx_byte[ADDR_W-1:0];
            step  <= rx_byte[DATA_W-1];
            state <= FR_DATA;
          end
          FR_DATA: begin
            wr_en   <= 1'b1;
            wr_addr <= ptr;
            wr_data <= rx_byte;
            if (step) ptr <= ptr + 1'b1;
          end
          default: state <= FR_SKIP;
        endcase
      end
    end
  end

endmodule

// File: rtl/spi_regport_bank.sv
module spi_regport_bank #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/spi_regport.sv
module spi_regport #(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] CHIP_ID = 8'b1001_1110,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);

  logic              cs_idle;
  logic              sclk_rise;
  logic              sdi_s;
  logic [CNT_W-1:0]  bit_cnt;
  logic              byte_valid;
  logic [DATA_W-1:0] rx_byte;
  logic              rx_busy;

  assign rx_busy = |bit_cnt;

  spi_regport_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .sdi       (sdi),
    .cs_idle   (cs_idle),
    .sclk_rise (sclk_rise),
    .sdi_s     (sdi_s)
  );

  spi_regport_rx #(.DATA_W(DATA_W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_idle    (cs_idle),
    .sclk_rise  (sclk_rise),
    .sdi_s      (sdi_s),
    .bit_cnt    (bit_cnt),
    .byte_valid (byte_valid),
    .rx_byte    (rx_byte)
  );

  spi_regport_frame #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .CHIP_ID (CHIP_ID)
  ) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_idle    (cs_idle),
    .byte_valid (byte_valid),
    .rx_byte    (rx_byte),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data)
  );

  spi_regport_bank #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

endmodule

// File: rtl/spi_regport_chk.sv
module spi_regport_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_idle,
  input logic rx_busy,
  input logic byte_valid,
  input logic wr_en
);

  // R8: an inactive select leaves the bit counter at zero
  a_r8_idle_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
    cs_idle |=> !rx_busy);

  // R10: no write strobe follows an inactive select
  a_r10_idle_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
    cs_idle |=> !wr_en);

  // R10: the strobe lasts exactly one cycle
  a_r10_single_cycle_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  // R2: a write is always caused by a byte completed in the cycle before
  a_r2_write_follows_byte: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(byte_valid));

  // R8: bytes complete only while select was active
  a_r8_byte_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> !$past(cs_idle));

endmodule

bind spi_regport spi_regport_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_idle    (cs_idle),
  .rx_busy    (rx_busy),
  .byte_valid (byte_valid),
  .wr_en      (wr_en)
);

// File: tb/test_spi_regport.sv
module test_spi_regport;

  localparam int HALF = 4;
  localparam logic [7:0] ID_OK = 8'h9E;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       sclk = 1'b0;
  logic       sdi = 1'b0;
  logic [6:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       wr_en;
  logic [6:0] wr_addr;
  logic [7:0] wr_data;

  always #10 clk = ~clk;

  spi_regport i_spi_regport (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .sclk    (sclk),
    .sdi     (sdi),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
  );

  int compared = 0;
  int mismatched = 0;
  int wr_seen = 0;
  bit done = 1'b0;
  logic [7:0] model [128];
  logic [7:0] pay [200];
  int pay_n = 0;

  always @(negedge clk) if (rst_n && wr_en) wr_seen++;

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      sdi = b[i];
      hold(HALF);
      sclk = 1'b1;
      hold(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic open_frame();
    cs_n = 1'b0;
    hold(HALF);
  endtask

  task automatic close_frame();
    hold(HALF);
    cs_n = 1'b1;
    hold(12);
  endtask

  task automatic run_txn(input logic [7:0] id, input logic [7:0] ptr);
    open_frame();
    send_bits(id, 8);
    send_bits(ptr, 8);
    for (int k = 0; k < pay_n; k++) send_bits(pay[k], 8);
    close_frame();
  endtask

  // expected effect of an accepted transfer, computed from the requirements
  task automatic model_apply(input logic [7:0] ptr);
    int a;
    a = int'(ptr[6:0]);
    for (int k = 0; k < pay_n; k++) begin
      model[a] = pay[k];
      if (ptr[7]) a = (a + 1) % 128;
    end
  endtask

  task automatic check_bank(input string req);
    for (int a = 0; a < 128; a++) begin
      rd_addr = 7'(a);
      hold(1);
      chk(rd_data === model[a], req, int'(rd_data), int'(model[a]));
    end
  endtask

  initial begin
    int w0;
    logic [7:0] bad;
    for (int a = 0; a < 128; a++) model[a] = 8'h00;
    hold(3);
    rst_n = 1'b1;
    hold(2);

    // R1: reset state
    chk(wr_en === 1'b0, "R1 wr_en after reset", int'(wr_en), 0);
    check_bank("R1 bank after reset");

    // R3 / R4: single byte to a chosen register, MSB first
    pay[0] = 8'h01; pay_n = 1;
    run_txn(ID_OK, 8'h05); model_apply(8'h05);
    rd_addr = 7'd5; hold(1);
    chk(rd_data === 8'h01, "R4 msb-first byte", int'(rd_data), 1);
    pay[0] = 8'hC3;
    run_txn(ID_OK, 8'h6B); model_apply(8'h6B);
    check_bank("R3 pointer selects register");

    // R5 / R10: full sweep in stepping mode
    w0 = wr_seen;
    pay_n = 128;
    for (int k = 0; k < 128; k++) pay[k] = 8'((k * 37 + 11) & 255);
    run_txn(ID_OK, 8'h80); model_apply(8'h80);
    chk(wr_seen - w0 == 128, "R10 one strobe per byte (sweep)", wr_seen - w0, 128);
    check_bank("R5 stepping sweep");

    // R7: wrap from 127 to 0
    pay_n = 4;
    for (int k = 0; k < 4; k++) pay[k] = 8'hE0 + 8'(k);
    run_txn(ID_OK, 8'h80 | 8'd126); model_apply(8'h80 | 8'd126);
    check_bank("R7 index wrap");

    // R6: fixed pointer, last byte stays
    w0 = wr_seen;
    pay_n = 3; pay[0] = 8'h11; pay[1] = 8'h22; pay[2] = 8'h33;
    run_txn(ID_OK, 8'h0A); model_apply(8'h0A);
    rd_addr = 7'd10; hold(1);
    chk(rd_data === 8'h33, "R6 fixed pointer keeps last byte", int'(rd_data), 8'h33);
    rd_addr = 7'd11; hold(1);
    chk(rd_data === model[11], "R6 neighbour untouched", int'(rd_data), int'(model[11]));
    chk(wr_seen - w0 == 3, "R10 one strobe per byte (fixed)", wr_seen - w0, 3);

    // R2: wrong identification bytes
    pay_n = 1; pay[0] = 8'hA5;
    for (int b = 0; b < 9; b++) begin
      bad = (b < 8) ? (ID_OK ^ (8'h01 << b)) : 8'h00;
      w0 = wr_seen;
      run_txn(bad, 8'h20);
      chk(wr_seen == w0, "R2 no strobe for wrong id", wr_seen - w0, 0);
      rd_addr = 7'h20; hold(1);
      chk(rd_data === model[32], "R2 target unchanged", int'(rd_data), int'(model[32]));
    end

    // R9: transfers ending early
    w0 = wr_seen;
    pay_n = 0;
    run_txn(ID_OK, 8'h30);
    open_frame(); send_bits(ID_OK, 8); close_frame();
    chk(wr_seen == w0, "R9 no write without data byte", wr_seen - w0, 0);
    check_bank("R9 bank unchanged");

    // R8: abort mid-byte, then a clean transfer decodes correctly
    w0 = wr_seen;
    open_frame(); send_bits(ID_OK, 8); send_bits(8'h40, 8); send_bits(8'hFF, 4); close_frame();
    open_frame(); send_bits(ID_OK, 3); close_frame();
    chk(wr_seen == w0, "R8 partial byte discarded", wr_seen - w0, 0);
    pay_n = 1; pay[0] = 8'h5A;
    run_txn(ID_OK, 8'h41); model_apply(8'h41);
    rd_addr = 7'h41; hold(1);
    chk(rd_data === 8'h5A, "R8 next transfer after abort", int'(rd_data), 8'h5A);
    check_bank("R8 bank after abort");

    chk(wr_en === 1'b0, "R10 strobe idle at end", int'(wr_en), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired (R10 progress) actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule